// File: doc/BRIEF.md
# Reserved-Opcode NOP Sequencer

This block executes the reserved (undefined) opcodes of a small 8-bit processor core. The fetch stage presents an opcode byte with a valid strobe. The block classifies the byte into one of six length and cycle classes. It then requests and discards the right number of operand bytes and spends the right number of bus cycles. No register, flag or memory location changes. A one-cycle pulse on `done` marks the last cycle, so the fetch stage can present the next opcode.

The block also gates interrupt recognition at instruction boundaries. A reserved opcode that takes one byte and one cycle sets a hold flag. While the flag is set, a pending interrupt is not taken, so an unbroken run of such opcodes keeps interrupts out. The first instruction of any other kind clears the flag, whether it is a longer reserved opcode or a defined opcode. Defined opcodes bypass the sequencer; their only effect here is to clear the flag.

A build parameter selects the core variant. On the variant with wait and stop instructions, codes CB and DB are defined and therefore bypass the sequencer.

Top module: `undef_op_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fetch_req`, `irq_hold` and `irq_take` are 0, and `bytes_used` and `op_class` are 0.
- R2: Codes with low nibble 3, and codes 0B,1B,2B,...,BB,EB,FB, take 1 byte and 1 cycle. With `tick` and `fetch_ack` held high, `done` is high right after the accepting edge (edge 1), and no operand fetch is requested.
- R3: Codes 02,22,42,62,82,C2,E2 take 2 bytes and 2 cycles. `done` follows edge 2, and one operand fetch is made.
- R4: Code 44 takes 2 bytes and 3 cycles. Codes 54,D4,F4 take 2 bytes and 4 cycles.
- R5: Code 5C takes 3 bytes and 8 cycles. Codes DC,FC take 3 bytes and 4 cycles.
- R6: With HAS_WAIT_STOP=1, CB and DB are treated as defined (bypass). With HAS_WAIT_STOP=0, they are 1-byte, 1-cycle reserved codes.
- R7: An opcode is accepted only on an edge where `tick` is high. A busy cycle advances only on an edge where `tick` is high. An operand fetch cycle (`fetch_req` high) also needs `fetch_ack`. Operand fetches come first, and `fetch_req` is never high while idle.
- R8: `op_valid` is ignored while `busy` is high. `done` timing, `op_class`, `bytes_used` and `irq_hold` are unaffected.
- R9: `irq_hold` is set when a 1-byte, 1-cycle code is accepted. It is cleared when any other instruction is accepted, reserved or defined, and otherwise holds its value.
- R10: `irq_take` is high exactly when `done`, `irq_pend` and not `irq_hold` are all true in the same cycle.
- R11: A defined opcode (`op_defined`=1, or a code not listed in R2 to R5) never raises `busy`, `done` or `fetch_req`.
- R12: When a reserved code is accepted, `bytes_used` takes its length. `op_class` takes its class: 1 = 1B/1C, 2 = 2B/2C, 3 = 2B/3C, 4 = 2B/4C, 5 = 3B/8C, 6 = 3B/4C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode byte presented |
| op_byte | input | 8 | Opcode byte |
| op_defined | input | 1 | Opcode is a defined instruction; bypass |
| tick | input | 1 | Bus cycle enable |
| fetch_req | output | 1 | Operand byte fetch request |
| fetch_ack | input | 1 | Operand byte delivered (discarded) |
| irq_pend | input | 1 | Interrupt pending |
| busy | output | 1 | Multi-cycle reserved opcode in progress |
| done | output | 1 | Last cycle of a reserved opcode completed |
| bytes_used | output | 2 | Length of the last accepted reserved opcode |
| op_class | output | 3 | Class code of the last accepted reserved opcode |
| irq_hold | output | 1 | Interrupt recognition held off |
| irq_take | output | 1 | Pending interrupt may be accepted at this boundary |

## Verification
The bench builds the default instance with HAS_WAIT_STOP=1 and CNT_W=4. It builds a second instance with HAS_WAIT_STOP=0, so that both decodes of CB and DB can be compared under the same stimulus. A counter width of 4 is the smallest that holds the 8-cycle class, which brings the longest count and its final-cycle compare into reach. It also sweeps all 256 codes against lengths and cycle counts computed in the bench. Stall patterns with withheld acknowledges and tick gaps check that every stall cycle adds exactly one edge.

// File: rtl/undef_op_pkg.sv
package undef_op_pkg;

  typedef enum logic [2:0] {
    CL_DEF  = 3'd0,
    CL_B1C1 = 3'd1,
    CL_B2C2 = 3'd2,
    CL_B2C3 = 3'd3,
    CL_B2C4 = 3'd4,
    CL_B3C8 = 3'd5,
    CL_B3C4 = 3'd6
  } op_class_e;

  localparam int MAX_CYC = 8;

  // instruction length in bytes for a class
  function automatic logic [1:0] len_of(op_class_e c);
    case (c)
      CL_B1C1:                    return 2'd1;
      CL_B2C2, CL_B2C3, CL_B2C4:  return 2'd2;
      CL_B3C8, CL_B3C4:           return 2'd3;
      default:                    return 2'd0;
    endcase
  endfunction

  // bus cycles for a class
  function automatic logic [3:0] cyc_of(op_class_e c);
    case (c)
      CL_B1C1: return 4'd1;
      CL_B2C2: return 4'd2;
      CL_B2C3: return 4'd3;
      CL_B2C4: return 4'd4;
      CL_B3C8: return 4'd8;
      CL_B3C4: return 4'd4;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/undef_op_decode.sv
module undef_op_decode
  import undef_op_pkg::*;
#(
  parameter bit HAS_WAIT_STOP = 1'b1
) (
  input  logic [7:0] op,
  output op_class_e  cls
);
  logic [3:0] hi, lo;
  logic       wb_excl;

  assign hi = op[7:4];
  assign lo = op[3:0];

  generate
    if (HAS_WAIT_STOP) begin : g_ws
      assign wb_excl = (hi == 4'hC) || (hi == 4'hD);
    end else begin : g_nows
      assign wb_excl = 1'b0;
    end
  endgenerate

  always_comb begin
    cls = CL_DEF;
    case (lo)
      4'h3: cls = CL_B1C1;
      4'hB: cls = wb_excl ? CL_DEF : CL_B1C1;
      4'h2: if (!hi[0] && hi != 4'hA) cls = CL_B2C2;
      4'h4: begin
        if (hi == 4'h4) cls = CL_B2C3;
        else if (hi == 4'h5 || hi == 4'hD || hi == 4'hF) cls = CL_B2C4;
      end
      4'hC: begin
        if (hi == 4'h5) cls = CL_B3C8;
        else if (hi == 4'hD || hi == 4'hF) cls = CL_B3C4;
      end
      default: cls = CL_DEF;
    endcase
  end
endmodule

// File: rtl/undef_op_count.sv
module undef_op_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cyc_init,
  input  logic [1:0]       byt_init,
  input  logic             tick,
  input  logic             fetch_ack,
  output logic             busy,
  output logic             fetch_req,
  output logic             fin
);
  logic [CNT_W-1:0] cyc_left;
  logic [1:0]       byt_left;
  logic             adv;

  assign fetch_req = busy && (byt_left != 2'd0);
  assign adv       = busy && tick && (!fetch_req || fetch_ack);
  assign fin       = adv && (cyc_left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cyc_left <= '0;
      byt_left <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      cyc_left <= cyc_init - CNT_W'(1);
      byt_left <= byt_init - 2'd1;
    end else if (adv) begin
      cyc_left <= cyc_left - CNT_W'(1);
      if (fetch_req) byt_left <= byt_left - 2'd1;
      if (fin) busy <= 1'b0;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adv) |=> (busy && $stable(cyc_left) && $stable(byt_left)));

  // R7
  fetch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (CNT_W'(byt_left) <= cyc_left));
endmodule

// File: rtl/undef_op_irqgate.sv
module undef_op_irqgate (
  input  logic clk,
  input  logic rst_n,
  input  logic set_hold,
  input  logic clr_hold,
  input  logic done,
  input  logic irq_pend,
  output logic irq_hold,
  output logic irq_take
);
  always_ff @(posedge clk) begin
    if (!rst_n)        irq_hold <= 1'b0;
    else if (set_hold) irq_hold <= 1'b1;
    else if (clr_hold) irq_hold <= 1'b0;
  end

  assign irq_take = done && irq_pend && !irq_hold;

  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_hold && !clr_hold) |=> $stable(irq_hold));

  // R9
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_hold |=> irq_hold);
endmodule

// File: rtl/undef_op_seq.sv
module undef_op_seq
  import undef_op_pkg::*;
#(
  parameter bit HAS_WAIT_STOP = 1'b1,
  parameter int CNT_W         = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [7:0] op_byte,
  input  logic       op_defined,
  input  logic       tick,
  output logic       fetch_req,
  input  logic       fetch_ack,
  input  logic       irq_pend,
  output logic       busy,
  output logic       done,
  output logic [1:0] bytes_used,
  output logic [2:0] op_class,
  output logic       irq_hold,
  output logic       irq_take
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  op_class_e  cls;
  logic       accept, reserved, take_res, take_one, take_multi, take_def;
  logic       fin;
  logic       done_q;
  logic [1:0] bytes_q;
  op_class_e  class_q;

  undef_op_decode #(.HAS_WAIT_STOP(HAS_WAIT_STOP)) u_dec (
    .op  (op_byte),
    .cls (cls)
  );

  assign accept     = op_valid && tick && !busy;
  assign reserved   = !op_defined && (cls != CL_DEF);
  assign take_res   = accept && reserved;
  assign take_one   = take_res && (cls == CL_B1C1);
  assign take_multi = take_res && (cls != CL_B1C1);
  assign take_def   = accept && !reserved;

  undef_op_count #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (take_multi),
    .cyc_init  (CNT_W'(cyc_of(cls))),
    .byt_init  (len_of(cls)),
    .tick      (tick),
    .fetch_ack (fetch_ack),
    .busy      (busy),
    .fetch_req (fetch_req),
    .fin       (fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      bytes_q <= 2'd0;
      class_q <= CL_DEF;
    end else begin
      done_q <= take_one || fin;
      if (take_res) begin
        bytes_q <= len_of(cls);
        class_q <= cls;
      end
    end
  end

  undef_op_irqgate u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_hold (take_one),
    .clr_hold (take_multi || take_def),
    .done     (done_q),
    .irq_pend (irq_pend),
    .irq_hold (irq_hold),
    .irq_take (irq_take)
  );

  assign done       = done_q;
  assign bytes_used = bytes_q;
  assign op_class   = class_q;

  initial begin
    cnt_fits_chk: assert (CNT_MAX >= MAX_CYC);
  end

  // R7
  fetch_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> busy);

  // R2
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy || take_one));

  // R11
  def_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_def |=> (!busy && !done));

  // R8
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(op_class) && $stable(bytes_used)));

  // R10
  take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (done && irq_pend));
endmodule

// File: tb/undef_op_seq_test.sv
`timescale 1ns/1ps
module undef_op_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [7:0] op_byte = 8'h00;
  logic       op_defined = 1'b0;
  logic       tick = 1'b1;
  logic       fetch_ack = 1'b1;
  logic       irq_pend = 1'b0;
  logic       fetch_req, busy, done, irq_hold, irq_take;
  logic [1:0] bytes_used;
  logic [2:0] op_class;
  logic       fetch_req2, busy2, done2, irq_hold2, irq_take2;
  logic [1:0] bytes_used2;
  logic [2:0] op_class2;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  undef_op_seq uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .op_defined(op_defined), .tick(tick), .fetch_req(fetch_req),
    .fetch_ack(fetch_ack), .irq_pend(irq_pend), .busy(busy), .done(done),
    .bytes_used(bytes_used), .op_class(op_class), .irq_hold(irq_hold),
    .irq_take(irq_take)
  );

  undef_op_seq #(.HAS_WAIT_STOP(1'b0)) uut_nws (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .op_defined(op_defined), .tick(tick), .fetch_req(fetch_req2),
    .fetch_ack(fetch_ack), .irq_pend(irq_pend), .busy(busy2), .done(done2),
    .bytes_used(bytes_used2), .op_class(op_class2), .irq_hold(irq_hold2),
    .irq_take(irq_take2)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected cycles, from the requirement lists (0 = not reserved)
  function automatic int exp_cyc(input logic [7:0] op);
    if (op[3:0] == 4'h3) return 1;
    if (op inside {8'h0B,8'h1B,8'h2B,8'h3B,8'h4B,8'h5B,8'h6B,8'h7B,
                   8'h8B,8'h9B,8'hAB,8'hBB,8'hEB,8'hFB}) return 1;
    if (op inside {8'h02,8'h22,8'h42,8'h62,8'h82,8'hC2,8'hE2}) return 2;
    if (op == 8'h44) return 3;
    if (op inside {8'h54,8'hD4,8'hF4,8'hDC,8'hFC}) return 4;
    if (op == 8'h5C) return 8;
    return 0;
  endfunction

  function automatic int exp_len(input logic [7:0] op);
    int c = exp_cyc(op);
    if (c == 0) return 0;
    if (c == 1) return 1;
    if (op == 8'h5C || op == 8'hDC || op == 8'hFC) return 3;
    return 2;
  endfunction

  function automatic int exp_class(input int len, input int cyc);
    if (len == 1) return 1;
    if (len == 2) return (cyc == 2) ? 2 : (cyc == 3) ? 3 : 4;
    if (len == 3) return (cyc == 8) ? 5 : 6;
    return 0;
  endfunction

  // present one opcode, count edges until done (limit if none)
  task automatic issue(input logic [7:0] op, input bit def, input int limit,
                       output int edges, output int fetches, output bit took);
    @(negedge clk);
    op_byte = op; op_defined = def; op_valid = 1'b1;
    edges = 0; fetches = 0; took = 1'b0;
    while (edges < limit) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      op_valid = 1'b0;
      if (fetch_req) fetches++;
      if (done) begin
        took = irq_take;
        break;
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && fetch_req == 0, "R1 ctrl", {busy, done, fetch_req}, 0);
    chk(irq_hold == 0 && irq_take == 0, "R1 irq", {irq_hold, irq_take}, 0);
    chk(bytes_used == 0 && op_class == 0, "R1 class", {bytes_used, op_class}, 0);
  endtask

  // R2 R3 R4 R5 R11 R12: sweep every code
  task automatic t_sweep;
    int e, f; bit t;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] op = 8'(i);
      int c = exp_cyc(op);
      int l = exp_len(op);
      if (c == 0) begin
        issue(op, 1'b0, 3, e, f, t);
        chk(e == 3 && f == 0 && busy == 0, "R11 undefined code bypass", e, 3);
      end else begin
        issue(op, 1'b0, 12, e, f, t);
        chk(e == c, (c == 1) ? "R2 cycles" : (c == 2) ? "R3 cycles" :
                    (l == 3) ? "R5 cycles" : "R4 cycles", e, c);
        chk(f == l - 1, "R2-R5 operand fetch count", f, l - 1);
        chk(int'(bytes_used) == l, "R12 bytes_used", bytes_used, l);
        chk(int'(op_class) == exp_class(l, c), "R12 op_class", op_class, exp_class(l, c));
      end
    end
  endtask

  // R6: wait/stop variant parameter
  task automatic t_variant;
    int e, f; bit t;
    issue(8'h13, 1'b0, 3, e, f, t);  // sets hold in both
    @(negedge clk);
    op_byte = 8'hCB; op_defined = 1'b0; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk(done == 0 && busy == 0, "R6 CB bypass with wait/stop", done, 0);
    chk(irq_hold == 0, "R6 CB clears hold with wait/stop", irq_hold, 0);
    chk(done2 == 1 && irq_hold2 == 1, "R6 CB is 1-cycle reserved without wait/stop",
        {done2, irq_hold2}, 3);
    @(negedge clk);
    op_byte = 8'hDB; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk(done == 0 && done2 == 1, "R6 DB", {done, done2}, 1);
  endtask

  // R7: stalls from withheld ack and tick gaps on 5C
  task automatic t_stall;
    int edges = 0, fetches = 0;
    @(negedge clk);
    op_byte = 8'h5C; op_defined = 1'b0; op_valid = 1'b1; tick = 1'b1; fetch_ack = 1'b1;
    while (edges < 20) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      op_valid = 1'b0;
      if (fetch_req && fetch_ack && tick) fetches++;
      if (done) break;
      fetch_ack = !((edges + 1) == 2 || (edges + 1) == 3);
      tick      = ((edges + 1) != 6);
    end
    tick = 1'b1; fetch_ack = 1'b1;
    chk(edges == 11, "R7 stalled 5C edge count", edges, 11);
    chk(fetches == 2, "R7 stalled 5C fetches", fetches, 2);
    // tick low blocks acceptance
    @(negedge clk);
    op_byte = 8'h02; op_valid = 1'b1; tick = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(busy == 0, "R7 no accept without tick", busy, 0);
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk(busy == 1 && fetch_req == 1, "R7 accept with tick", {busy, fetch_req}, 3);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1, "R7 02 finishes", done, 1);
  endtask

  // R8: opcode presented while busy is ignored
  task automatic t_ignore;
    int edges = 0;
    @(negedge clk);
    op_byte = 8'h5C; op_defined = 1'b0; op_valid = 1'b1;
    while (edges < 20) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      op_valid = (edges >= 2 && edges <= 4);
      op_byte  = (edges >= 2) ? 8'h03 : 8'h5C;
      if (done) break;
    end
    op_valid = 1'b0;
    chk(edges == 8, "R8 done timing unchanged", edges, 8);
    chk(op_class == 5 && bytes_used == 3, "R8 class unchanged", op_class, 5);
    chk(irq_hold == 0, "R8 hold untouched", irq_hold, 0);
  endtask

  // R9 R10 R11: interrupt gating
  task automatic t_irq;
    int e, f; bit t;
    irq_pend = 1'b1;
    issue(8'h02, 1'b0, 12, e, f, t);
    chk(t == 1, "R10 take after 2-cycle", t, 1);
    issue(8'h03, 1'b0, 12, e, f, t);
    chk(t == 0 && irq_hold == 1, "R9 R10 1-cycle holds off", {t, irq_hold}, 1);
    issue(8'hFB, 1'b0, 12, e, f, t);
    chk(t == 0 && irq_hold == 1, "R9 run of 1-cycle", {t, irq_hold}, 1);
    issue(8'h44, 1'b0, 12, e, f, t);
    chk(t == 1 && irq_hold == 0, "R9 R10 longer op resumes", {t, irq_hold}, 2);
    issue(8'h33, 1'b0, 12, e, f, t);
    issue(8'h03, 1'b1, 3, e, f, t);  // reserved code flagged defined
    chk(e == 3 && irq_hold == 0, "R11 R9 defined clears hold", {e, irq_hold}, 6);
    irq_pend = 1'b0;
    issue(8'hD4, 1'b0, 12, e, f, t);
    chk(t == 0 && e == 4, "R10 no take without pending", {t, e}, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sweep();
    t_variant();
    t_stall();
    t_ignore();
    t_irq();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule